// File: doc/BRIEF.md
# Operand Effective-Address Sequencer

This unit works out the 16-bit address that an instruction operand lives at, for a small 8-bit accumulator machine. A start pulse brings in a 4-bit mode code, the program counter (already pointing at the first operand byte) and the two index registers. The unit then fetches operand bytes, and for the indirect modes pointer bytes, through a byte-wide read port. That port returns data one cycle after each request. When the address is ready, the unit presents it together with a one-cycle done pulse.

The unit decodes no opcodes and moves no data. It does not add extra cycles when an index carries into the next page. All arithmetic on zero-page pointers and zero-page indexing wraps inside the first 256 bytes. Indexed absolute addressing and the post-indexed indirect result wrap across the whole 64 KiB space. Any code that does not select an addressing mode ends the request at once with an error flag.

Top module: `operand_addr_gen`

## Requirements
- R1: While reset is held and on the first cycle after it, `busy_o`, `rd_en_o`, `done_o` and `err_o` are low and `ea_o` is zero.
- R2: Mode 0 (immediate) issues no read and gives `ea_o` equal to the captured program counter. `done_o` is high in the cycle after the start edge.
- R3: Mode 1 (zero page) reads one byte at PC and gives `ea_o` = {8'h00, byte}.
- R4: Modes 2 and 3 (zero page plus X or plus Y) give {8'h00, (byte + index) mod 256}.
- R5: Mode 4 (absolute) reads PC and then (PC+1) mod 65536. `ea_o` = {second byte, first byte}.
- R6: Modes 5 and 6 (absolute plus X or plus Y) add the zero-extended index to the absolute base, modulo 65536.
- R7: Mode 7 (pre-indexed indirect) forms p = (operand + X) mod 256. It reads the low byte at p and the high byte at (p+1) mod 256.
- R8: Mode 8 (post-indexed indirect) reads a base from zero-page addresses operand and (operand+1) mod 256, low byte first. Y is then added modulo 65536.
- R9: Modes 9 to 15 issue no read. `done_o` and `err_o` rise together in the cycle after the start edge, and `ea_o` keeps its previous value.
- R10: Reads go out one at a time. Each `rd_en_o` pulse lasts one cycle and is followed by one cycle without a read. The data is taken in that following cycle. If start is sampled at edge t and the mode needs n reads, read k (k = 0, 1, 2) is requested in the cycle after edge t+2k, and `done_o` is high in the cycle after edge t+2n.
- R11: `start_i` is honoured only when `busy_o` is low. A start seen while busy, including during the done cycle, changes nothing.
- R12: `done_o` lasts exactly one cycle, and `ea_o` changes only on the cycle that `done_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request a new address computation |
| mode_i | input | 4 | Addressing-mode code |
| pc_i | input | 16 | Address of the first operand byte |
| idx_x_i | input | 8 | X index register |
| idx_y_i | input | 8 | Y index register |
| rd_en_o | output | 1 | Memory read request |
| rd_addr_o | output | 16 | Memory read address |
| rd_data_i | input | 8 | Read data, valid the cycle after the request |
| busy_o | output | 1 | A request is in progress (including the done cycle) |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Unsupported mode, high with done |
| ea_o | output | 16 | Effective address |

## Verification
Every result has a fixed due cycle measured from the edge that samples start. For a mode needing n reads, read k is requested in cycle 2k+1 after that edge and done with the address comes in cycle 2n+1. Immediate and invalid modes are therefore due in cycle 1. The bench's reference model precomputes the read addresses and final address from the mode rules. It then walks the same cycle count, sampling on the falling edge and comparing busy, read request, read address, done, error and address on every one of those cycles and on the idle cycle that follows.

// File: rtl/oag_pkg.sv
package oag_pkg;

    localparam logic [3:0] AM_IMM  = 4'd0;
    localparam logic [3:0] AM_ZP   = 4'd1;
    localparam logic [3:0] AM_ZPX  = 4'd2;
    localparam logic [3:0] AM_ZPY  = 4'd3;
    localparam logic [3:0] AM_ABS  = 4'd4;
    localparam logic [3:0] AM_ABSX = 4'd5;
    localparam logic [3:0] AM_ABSY = 4'd6;
    localparam logic [3:0] AM_INDX = 4'd7;
    localparam logic [3:0] AM_INDY = 4'd8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } st_e;

    typedef enum logic [2:0] {
        CAT_IMM,
        CAT_ZP,
        CAT_ABS,
        CAT_PRE,
        CAT_POST
    } cat_e;

    typedef enum logic [1:0] {
        IDX_NONE,
        IDX_X,
        IDX_Y
    } idx_sel_e;

    typedef struct packed {
        logic     valid;
        logic [1:0] nreads;
        cat_e     cat;
        idx_sel_e idx;
    } mode_info_t;

endpackage

// File: rtl/oag_wrap_add.sv
module oag_wrap_add #(
    parameter int AW      = 16,
    parameter int DW      = 8,
    parameter int BASE_W  = 16,
    parameter bit ZP_WRAP = 1'b0
) (
    input  logic [BASE_W-1:0] base_i,
    input  logic [DW-1:0]     inc_i,
    output logic [AW-1:0]     sum_o
);

    localparam int HI_W = AW - DW;

    generate
        if (ZP_WRAP) begin : g_page
            // keep the carry inside the zero page
            logic [DW-1:0] low;
            assign low   = base_i[DW-1:0] + inc_i;
            assign sum_o = {{HI_W{1'b0}}, low};
        end else begin : g_full
            assign sum_o = AW'(base_i) + AW'(inc_i);
        end
    endgenerate

endmodule

// File: rtl/oag_mode_decode.sv
module oag_mode_decode
    import oag_pkg::*;
#(
    parameter int MODE_W = 4
) (
    input  logic [MODE_W-1:0] mode_i,
    output mode_info_t        info_o
);

    always_comb begin
        info_o = '{valid: 1'b1, nreads: 2'd0, cat: CAT_IMM, idx: IDX_NONE};
        case (mode_i)
            AM_IMM:  info_o = '{valid: 1'b1, nreads: 2'd0, cat: CAT_IMM,  idx: IDX_NONE};
            AM_ZP:   info_o = '{valid: 1'b1, nreads: 2'd1, cat: CAT_ZP,   idx: IDX_NONE};
            AM_ZPX:  info_o = '{valid: 1'b1, nreads: 2'd1, cat: CAT_ZP,   idx: IDX_X};
            AM_ZPY:  info_o = '{valid: 1'b1, nreads: 2'd1, cat: CAT_ZP,   idx: IDX_Y};
            AM_ABS:  info_o = '{valid: 1'b1, nreads: 2'd2, cat: CAT_ABS,  idx: IDX_NONE};
            AM_ABSX: info_o = '{valid: 1'b1, nreads: 2'd2, cat: CAT_ABS,  idx: IDX_X};
            AM_ABSY: info_o = '{valid: 1'b1, nreads: 2'd2, cat: CAT_ABS,  idx: IDX_Y};
            AM_INDX: info_o = '{valid: 1'b1, nreads: 2'd3, cat: CAT_PRE,  idx: IDX_X};
            AM_INDY: info_o = '{valid: 1'b1, nreads: 2'd3, cat: CAT_POST, idx: IDX_Y};
            default: info_o = '{valid: 1'b0, nreads: 2'd0, cat: CAT_IMM,  idx: IDX_NONE};
        endcase
    end

endmodule

// File: rtl/oag_addr_calc.sv
module oag_addr_calc
    import oag_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 8
) (
    input  cat_e                 cat_i,
    input  idx_sel_e             idx_i,
    input  logic [1:0]           step_i,
    input  logic [AW-1:0]        pc_i,
    input  logic [DW-1:0]        x_i,
    input  logic [DW-1:0]        y_i,
    input  logic [2:0][DW-1:0]   bytes_i,
    output logic [AW-1:0]        rd_addr_o,
    output logic [AW-1:0]        ea_o
);

    localparam int HI_W = AW - DW;

    logic [DW-1:0] sel_idx;
    logic [AW-1:0] zp_sum;
    logic [DW-1:0] ptr;
    logic [AW-1:0] ptr_next;
    logic [AW-1:0] pc_next;
    logic [AW-1:0] full_base;
    logic [AW-1:0] full_sum;

    assign sel_idx = (idx_i == IDX_Y) ? y_i : x_i;

    // operand byte plus index, kept in page zero
    oag_wrap_add #(.AW(AW), .DW(DW), .BASE_W(DW), .ZP_WRAP(1'b1)) u_zp_sum (
        .base_i (bytes_i[0]),
        .inc_i  (sel_idx),
        .sum_o  (zp_sum)
    );

    assign ptr = (cat_i == CAT_PRE) ? zp_sum[DW-1:0] : bytes_i[0];

    // second pointer byte, kept in page zero
    oag_wrap_add #(.AW(AW), .DW(DW), .BASE_W(DW), .ZP_WRAP(1'b1)) u_ptr_next (
        .base_i (ptr),
        .inc_i  (DW'(1)),
        .sum_o  (ptr_next)
    );

    // second operand byte, full-space wrap
    oag_wrap_add #(.AW(AW), .DW(DW), .BASE_W(AW), .ZP_WRAP(1'b0)) u_pc_next (
        .base_i (pc_i),
        .inc_i  (DW'(1)),
        .sum_o  (pc_next)
    );

    assign full_base = (cat_i == CAT_POST) ? AW'({bytes_i[2], bytes_i[1]})
                                           : AW'({bytes_i[1], bytes_i[0]});

    oag_wrap_add #(.AW(AW), .DW(DW), .BASE_W(AW), .ZP_WRAP(1'b0)) u_full_sum (
        .base_i (full_base),
        .inc_i  (sel_idx),
        .sum_o  (full_sum)
    );

    always_comb begin
        case (step_i)
            2'd0:    rd_addr_o = pc_i;
            2'd1:    rd_addr_o = (cat_i == CAT_ABS) ? pc_next : {{HI_W{1'b0}}, ptr};
            2'd2:    rd_addr_o = ptr_next;
            default: rd_addr_o = pc_i;
        endcase
    end

    always_comb begin
        case (cat_i)
            CAT_ZP:   ea_o = (idx_i == IDX_NONE) ? {{HI_W{1'b0}}, bytes_i[0]} : zp_sum;
            CAT_ABS:  ea_o = (idx_i == IDX_NONE) ? full_base : full_sum;
            CAT_PRE:  ea_o = AW'({bytes_i[2], bytes_i[1]});
            CAT_POST: ea_o = full_sum;
            default:  ea_o = pc_i;
        endcase
    end

endmodule

// File: rtl/operand_addr_gen.sv
module operand_addr_gen
    import oag_pkg::*;
#(
    parameter int AW     = 16,
    parameter int DW     = 8,
    parameter int MODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [MODE_W-1:0] mode_i,
    input  logic [AW-1:0]     pc_i,
    input  logic [DW-1:0]     idx_x_i,
    input  logic [DW-1:0]     idx_y_i,
    output logic              rd_en_o,
    output logic [AW-1:0]     rd_addr_o,
    input  logic [DW-1:0]     rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic [AW-1:0]     ea_o
);

    typedef struct packed {
        st_e                st;
        logic [1:0]         step;
        logic [1:0]         nreads;
        cat_e               cat;
        idx_sel_e           idx;
        logic [AW-1:0]      pc;
        logic [DW-1:0]      x;
        logic [DW-1:0]      y;
        logic [2:0][DW-1:0] bytes;
        logic [AW-1:0]      ea;
        logic               err;
    } regs_t;

    regs_t              r_q, r_d;
    mode_info_t         dec_info;
    logic [2:0][DW-1:0] bytes_cap;
    logic [AW-1:0]      calc_rd_addr;
    logic [AW-1:0]      calc_ea;

    oag_mode_decode #(.MODE_W(MODE_W)) u_decode (
        .mode_i (mode_i),
        .info_o (dec_info)
    );

    // bytes as they will be once the pending read data is taken
    always_comb begin
        bytes_cap = r_q.bytes;
        if (r_q.st == ST_WAIT) begin
            case (r_q.step)
                2'd0:    bytes_cap[0] = rd_data_i;
                2'd1:    bytes_cap[1] = rd_data_i;
                default: bytes_cap[2] = rd_data_i;
            endcase
        end
    end

    oag_addr_calc #(.AW(AW), .DW(DW)) u_calc (
        .cat_i     (r_q.cat),
        .idx_i     (r_q.idx),
        .step_i    (r_q.step),
        .pc_i      (r_q.pc),
        .x_i       (r_q.x),
        .y_i       (r_q.y),
        .bytes_i   (bytes_cap),
        .rd_addr_o (calc_rd_addr),
        .ea_o      (calc_ea)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.pc     = pc_i;
                    r_d.x      = idx_x_i;
                    r_d.y      = idx_y_i;
                    r_d.cat    = dec_info.cat;
                    r_d.idx    = dec_info.idx;
                    r_d.nreads = dec_info.nreads;
                    r_d.step   = 2'd0;
                    r_d.bytes  = '0;
                    if (!dec_info.valid) begin
                        r_d.st  = ST_DONE;
                        r_d.err = 1'b1;
                    end else if (dec_info.nreads == 2'd0) begin
                        r_d.st = ST_DONE;
                        r_d.ea = pc_i;
                    end else begin
                        r_d.st = ST_ISSUE;
                    end
                end
            end
            ST_ISSUE: begin
                r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                r_d.bytes = bytes_cap;
                if (r_q.step == r_q.nreads - 2'd1) begin
                    r_d.st = ST_DONE;
                    r_d.ea = calc_ea;
                end else begin
                    r_d.step = r_q.step + 2'd1;
                    r_d.st   = ST_ISSUE;
                end
            end
            default: begin
                r_d.st  = ST_IDLE;
                r_d.err = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_en_o   = (r_q.st == ST_ISSUE);
    assign rd_addr_o = rd_en_o ? calc_rd_addr : '0;
    assign busy_o    = (r_q.st != ST_IDLE);
    assign done_o    = (r_q.st == ST_DONE);
    assign err_o     = r_q.err;
    assign ea_o      = r_q.ea;

endmodule

// File: rtl/oag_checker.sv
module oag_checker #(
    parameter int AW     = 16,
    parameter int MODE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic [MODE_W-1:0] mode_i,
    input logic              busy_o,
    input logic              rd_en_o,
    input logic              done_o,
    input logic              err_o,
    input logic [AW-1:0]     ea_o
);

    assert_done_single_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_ea_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(ea_o));

    assert_read_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> !rd_en_o);

    assert_read_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> busy_o);

    assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    assert_no_start_no_work_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> !busy_o);

    assert_imm_no_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && mode_i == '0) |=> (done_o && !rd_en_o && !err_o));

endmodule

bind operand_addr_gen oag_checker #(.AW(AW), .MODE_W(MODE_W)) u_oag_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .mode_i  (mode_i),
    .busy_o  (busy_o),
    .rd_en_o (rd_en_o),
    .done_o  (done_o),
    .err_o   (err_o),
    .ea_o    (ea_o)
);

// File: tb/operand_addr_gen_tb_top.sv
`timescale 1ns/1ps
module operand_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [3:0]  mode_i = '0;
    logic [15:0] pc_i = '0;
    logic [7:0]  idx_x_i = '0;
    logic [7:0]  idx_y_i = '0;
    logic        rd_en_o;
    logic [15:0] rd_addr_o;
    logic [7:0]  rd_data_i = '0;
    logic        busy_o;
    logic        done_o;
    logic        err_o;
    logic [15:0] ea_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] last_ea = '0;
    logic [7:0]  mem_over [int];

    always #2.5 clk = ~clk;

    operand_addr_gen dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mode_i    (mode_i),
        .pc_i      (pc_i),
        .idx_x_i   (idx_x_i),
        .idx_y_i   (idx_y_i),
        .rd_en_o   (rd_en_o),
        .rd_addr_o (rd_addr_o),
        .rd_data_i (rd_data_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .err_o     (err_o),
        .ea_o      (ea_o)
    );

    function automatic logic [7:0] memf(input logic [15:0] a);
        if (mem_over.exists(int'(a))) return mem_over[int'(a)];
        return 8'(int'(a[7:0]) * 7 + int'(a[15:8]) * 13 + 5);
    endfunction

    // memory with one cycle of read latency
    always @(posedge clk) begin
        if (rd_en_o) rd_data_i <= memf(rd_addr_o);
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // behavioural reference: reads due in cycles 1,3,5 after start edge, done in 2n+1
    task automatic run_op(input string req, input logic [3:0] mode, input logic [15:0] pc,
                          input logic [7:0] x, input logic [7:0] y, input bit hold);
        int n;
        logic [15:0] ra [3];
        logic [15:0] exp_ea;
        logic [15:0] base;
        logic [7:0]  op, p;
        bit          exp_err;
        n = 0; exp_err = 0; exp_ea = last_ea;
        ra[0] = pc; ra[1] = '0; ra[2] = '0;
        op = memf(pc);
        case (mode)
            4'd0: exp_ea = pc;
            4'd1: begin n = 1; exp_ea = {8'h00, op}; end
            4'd2: begin n = 1; exp_ea = {8'h00, 8'(op + x)}; end
            4'd3: begin n = 1; exp_ea = {8'h00, 8'(op + y)}; end
            4'd4, 4'd5, 4'd6: begin
                n = 2; ra[1] = 16'(pc + 1);
                base = {memf(ra[1]), op};
                exp_ea = (mode == 4'd4) ? base :
                         (mode == 4'd5) ? 16'(base + x) : 16'(base + y);
            end
            4'd7: begin
                n = 3; p = 8'(op + x);
                ra[1] = {8'h00, p}; ra[2] = {8'h00, 8'(p + 1)};
                exp_ea = {memf(ra[2]), memf(ra[1])};
            end
            4'd8: begin
                n = 3; ra[1] = {8'h00, op}; ra[2] = {8'h00, 8'(op + 1)};
                exp_ea = 16'({memf(ra[2]), memf(ra[1])} + y);
            end
            default: exp_err = 1;
        endcase
        @(negedge clk);
        mode_i = mode; pc_i = pc; idx_x_i = x; idx_y_i = y; start_i = 1'b1;
        for (int k = 1; k <= 2 * n + 2; k++) begin
            @(negedge clk);
            if (k == 1) begin
                if (hold) begin
                    // new request presented while busy: must be ignored (R11)
                    mode_i = 4'd4; pc_i = pc ^ 16'h5A5A; idx_x_i = ~x; idx_y_i = ~y;
                end else begin
                    start_i = 1'b0;
                end
            end
            if (k <= 2 * n) begin
                chk(req, "busy", busy_o, 1);
                chk(req, "rd_en R10", rd_en_o, k % 2);
                if (k % 2 == 1) chk(req, "rd_addr", rd_addr_o, ra[(k - 1) / 2]);
                chk(req, "done", done_o, 0);
                chk(req, "ea_hold R12", ea_o, last_ea);
            end else if (k == 2 * n + 1) begin
                chk(req, "done R10", done_o, 1);
                chk(req, "rd_en", rd_en_o, 0);
                chk(req, "err", err_o, exp_err);
                chk(req, "ea", ea_o, exp_ea);
            end else begin
                chk(req, "idle busy R12", busy_o, 0);
                chk(req, "idle done R12", done_o, 0);
                chk(req, "idle rd_en", rd_en_o, 0);
                chk(req, "idle ea R12", ea_o, exp_ea);
                start_i = 1'b0;
            end
        end
        last_ea = exp_ea;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: outputs during reset
        chk("R1", "busy", busy_o, 0);
        chk("R1", "rd_en", rd_en_o, 0);
        chk("R1", "done", done_o, 0);
        chk("R1", "err", err_o, 0);
        chk("R1", "ea", ea_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", busy_o, 0);
        chk("R1", "ea after reset", ea_o, 0);

        run_op("R2", 4'd0, 16'h1234, 8'h00, 8'h00, 0);
        run_op("R2", 4'd0, 16'hFFFF, 8'h11, 8'h22, 1);

        mem_over[16'h8000] = 8'h10;
        run_op("R3", 4'd1, 16'h8000, 8'h33, 8'h44, 0);
        mem_over[16'h8010] = 8'h80;
        run_op("R4", 4'd2, 16'h8010, 8'hFF, 8'h01, 0);
        mem_over[16'h8020] = 8'hF0;
        run_op("R4", 4'd3, 16'h8020, 8'h01, 8'h20, 0);

        mem_over[16'hFFFF] = 8'h34;
        mem_over[16'h0000] = 8'h12;
        run_op("R5", 4'd4, 16'hFFFF, 8'h00, 8'h00, 0);
        mem_over[16'h9000] = 8'hF0;
        mem_over[16'h9001] = 8'hFF;
        run_op("R6", 4'd5, 16'h9000, 8'h20, 8'h00, 0);
        run_op("R6", 4'd6, 16'h9000, 8'h00, 8'h0F, 0);

        mem_over[16'hA000] = 8'hFE;
        mem_over[16'h00FF] = 8'hCD;
        mem_over[16'h0001] = 8'hAB;
        mem_over[16'h0000] = 8'h77;
        run_op("R7", 4'd7, 16'hA000, 8'h01, 8'h00, 0);
        mem_over[16'hA100] = 8'h40;
        run_op("R7", 4'd7, 16'hA100, 8'h10, 8'h00, 0);

        mem_over[16'hB000] = 8'hFF;
        mem_over[16'h00FF] = 8'hF8;
        mem_over[16'h0000] = 8'hFF;
        run_op("R8", 4'd8, 16'hB000, 8'h00, 8'h10, 0);
        mem_over[16'hB100] = 8'h30;
        run_op("R8", 4'd8, 16'hB100, 8'h55, 8'h02, 1);

        run_op("R9", 4'd9, 16'h2222, 8'h00, 8'h00, 0);
        run_op("R9", 4'd15, 16'h3333, 8'h00, 8'h00, 1);

        run_op("R11", 4'd4, 16'h4444, 8'h00, 8'h00, 1);
        run_op("R11", 4'd1, 16'h5555, 8'h00, 8'h00, 1);

        for (int i = 0; i < 40; i++) begin
            run_op("R10", 4'(i % 11), 16'(i * 4099 + 17), 8'(i * 37), 8'(i * 91), (i % 3) == 0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule